// File: doc/BRIEF.md
# Multi-Rate Strobe Generator

The block derives a family of clock-enable strobes from one fast system clock. A single free-running binary counter advances on every cycle. Each output watches one counter bit and pulses high for exactly one system clock when that bit turns from 0 to 1. The top tapped bit gives the slowest strobe, and each following output uses the next lower bit, so it runs at twice the rate of the one before. Every output rate is the system clock divided by a power of two.

The slowest rate is set through two frequency parameters. The ratio between them is rounded up to the next power of two, so the real rate is equal to or slightly below the requested one. Downstream logic stays on the system clock and uses the strobes only as register enables, so no derived clocks appear and no crossing between clock domains is created. A built-in capture register shows this use: it takes a new sample only on the slowest strobe.

Top module: `cen_strobe_gen`

## Requirements
- R1: The counter is CNT_W = ceil(log2(IN_FREQ_HZ / LOW_FREQ_HZ)) bits wide, using integer division, and it wraps. The slowest strobe `strobe_o[0]` therefore repeats every 2^CNT_W clocks.
- R2: Output `strobe_o[k]` follows counter bit CNT_W-1-k and repeats every 2^(CNT_W-k) clocks.
- R3: A strobe is high for exactly one clock. Let n be the number of clocks since reset was released. `strobe_o[k]` is high exactly when n mod 2^(CNT_W-k) equals 2^(CNT_W-1-k).
- R4: At most one bit of `strobe_o` is high in any cycle.
- R5: `rst_ni` is a synchronous active-low reset. A clock edge with `rst_ni` low clears the counter, the edge-detect history and the capture register, and every strobe is low after that edge.
- R6: No strobe appears spuriously after reset. The first pulse on `strobe_o[k]` comes exactly 2^(CNT_W-1-k) clocks after reset is released.
- R7: On an edge where `strobe_o[0]` is high, `capture_o` loads `sample_i`. On every other edge outside reset it keeps its value. Reset clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; the only clock in the block |
| rst_ni | input | 1 | Synchronous reset, active low |
| sample_i | input | DATA_W | Data loaded into the capture register |
| strobe_o | output | NUM_OUT | One-cycle enables; bit 0 is the slowest, and each higher bit is twice as fast |
| capture_o | output | DATA_W | Last sample taken on the slowest strobe |

## Verification
Each strobe is a combinational decode of two registers. It therefore shows up in the cycle that follows the clock edge that moved the counter to the matching value. The reference model counts the edges since reset was released and predicts the strobe vector for the current count. The capture register takes one more edge: it holds `sample_i` as it stood at the edge where the slowest strobe was high. The bench updates its model at each rising edge and compares all outputs at the following falling edge, so every output is checked one half-period after it settles. Stimulus is driven only after that comparison.

// File: rtl/cen_pkg.sv
package cen_pkg;
  // ceil(log2(in/low)), at least 1
  function automatic int div_width(input int in_hz, input int low_hz);
    int ratio;
    ratio = in_hz / low_hz;
    if (ratio < 2) return 1;
    return $clog2(ratio);
  endfunction
endpackage

// File: rtl/cen_counter.sv
module cen_counter #(
  parameter int CNT_W = 8,
  parameter int TAP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [TAP_W-1:0] tap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign tap_o = cnt_q[CNT_W-1 -: TAP_W];

  a_r5_cnt_clear: assert property (@(posedge clk_i)
    !rst_ni |=> (cnt_q == '0));

  a_r1_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/cen_edge_det.sv
module cen_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic pulse_o
);
  logic level_d_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) level_d_q <= 1'b0;
    else         level_d_q <= level_i;
  end

  assign pulse_o = level_i & ~level_d_q;

  a_r3_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  a_r5_quiet_after_reset: assert property (@(posedge clk_i)
    !rst_ni |=> !pulse_o);
endmodule

// File: rtl/cen_capture.sv
module cen_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));

  a_r7_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/cen_strobe_gen.sv
module cen_strobe_gen #(
  parameter int IN_FREQ_HZ  = 50_000_000,
  parameter int LOW_FREQ_HZ = 1_000,
  parameter int NUM_OUT     = 4,
  parameter int DATA_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  output logic [NUM_OUT-1:0] strobe_o,
  output logic [DATA_W-1:0] capture_o
);
  localparam int CNT_W = cen_pkg::div_width(IN_FREQ_HZ, LOW_FREQ_HZ);

  logic [NUM_OUT-1:0] tap;

  cen_counter #(
    .CNT_W(CNT_W),
    .TAP_W(NUM_OUT)
  ) i_counter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tap_o (tap)
  );

  // output k follows counter bit CNT_W-1-k, i.e. tap bit NUM_OUT-1-k
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    cen_edge_det i_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .level_i(tap[NUM_OUT-1-k]),
      .pulse_o(strobe_o[k])
    );
  end

  cen_capture #(
    .DATA_W(DATA_W)
  ) i_capture (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (strobe_o[0]),
    .d_i   (sample_i),
    .q_o   (capture_o)
  );

  a_r4_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_o));
endmodule

// File: tb/test_cen_strobe_gen.sv
module test_cen_strobe_gen;
  localparam int IN_HZ  = 3200;
  localparam int LOW_HZ = 50;
  localparam int N      = 4;
  localparam int DW     = 8;
  localparam int W      = $clog2(IN_HZ / LOW_HZ);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [DW-1:0] smp   = '0;
  logic [N-1:0]  strobe;
  logic [DW-1:0] cap;

  cen_strobe_gen #(
    .IN_FREQ_HZ (IN_HZ),
    .LOW_FREQ_HZ(LOW_HZ),
    .NUM_OUT    (N),
    .DATA_W     (DW)
  ) i_cen_strobe_gen (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .sample_i (smp),
    .strobe_o (strobe),
    .capture_o(cap)
  );

  int total = 0;
  int bad   = 0;
  int m     = 0;
  int last[N];
  int cyc   = 0;
  bit done  = 0;
  logic [DW-1:0] cap_m = '0;

  function automatic logic [N-1:0] exp_strobe(input int mm);
    logic [N-1:0] e;
    for (int k = 0; k < N; k++) begin
      int b;
      b = W - 1 - k;
      e[k] = ((mm % (1 << (b + 1))) == (1 << b));
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  task automatic step();
    logic [N-1:0] e;
    @(posedge clk);
    if (!rst_n) begin
      m = 0;
      cap_m = '0;
    end else begin
      e = exp_strobe(m);
      if (e[0]) cap_m = smp;
      m++;
    end
    @(negedge clk);
    e = exp_strobe(m);
    if (!rst_n) begin
      check(strobe == '0, "R5 strobes low in reset", int'(strobe), 0);
      check(cap == '0, "R5 capture cleared", int'(cap), 0);
      for (int k = 0; k < N; k++) last[k] = -1;
    end
    check(strobe == e, "R3 strobe pattern", int'(strobe), int'(e));
    check($countones(strobe) <= 1, "R4 at most one strobe", $countones(strobe), 1);
    check(cap == cap_m, "R7 capture value", int'(cap), int'(cap_m));
    if (rst_n) begin
      for (int k = 0; k < N; k++) begin
        if (strobe[k]) begin
          if (last[k] >= 0) begin
            if (k == 0) check(m - last[k] == (1 << W), "R1 slowest period", m - last[k], 1 << W);
            else        check(m - last[k] == (1 << (W - k)), "R2 period", m - last[k], 1 << (W - k));
          end else begin
            check(m == (1 << (W - 1 - k)), "R6 first strobe", m, 1 << (W - 1 - k));
          end
          last[k] = m;
        end
      end
    end
  endtask

  initial begin
    for (int k = 0; k < N; k++) last[k] = -1;
    for (int i = 0; i < 700; i++) begin
      step();
      rst_n = !((i < 3) || (i >= 350 && i < 353));
      smp   = DW'(i * 37 + 11);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL R3 watchdog act=%0d exp=%0d", cyc, 700);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule